// File: doc/BRIEF.md
# Strobed Host Bus Port with Vectored Interrupt Acknowledge

This block is the host side of a peripheral that sits on a bus with separate address and data strobes. The host first pulses the address strobe low. On its rising edge the block captures the register address, an early active-low select and an active-low acknowledge flag. The data strobe then runs a read or a write against a small register file. A late active-high select must also be present for the cycle to take effect. All strobe inputs are asynchronous to the block. They are synchronized and edge-detected on a fast system clock.

If the acknowledge flag was captured low, the cycle is an interrupt-acknowledge cycle. In that case the address, both selects and the direction line are disregarded. Six interrupt sources are ranked in a fixed order, with index 0 the highest. At the data-strobe fall the block claims the cycle if the daisy-chain enable input is high and a source is pending. It then marks the winning source as in service and returns a vector on the data bus. The vector is a programmable base with the source index placed in bits 3:1. A chain output passes the enable on to lower-priority devices.

Top module: `strobe_host_port`

## Requirements
- R1: Address, early select and acknowledge flag are taken only at the address-strobe rising edge. Changing them afterwards does not alter the cycle in progress.
- R2: A read drives `bus_oe` high while the data strobe is low and `sel_late` is high. It returns the addressed location. `bus_oe` is low in every other cycle phase, including reads with `sel_late` low.
- R3: A write (`dir_rd` low at the data-strobe fall) stores `bus_wdata` on the data-strobe rise. It does so only if `sel_early_n` was low at the address-strobe edge and `sel_late` is high.
- R4: Register map: location 0 is the vector base, 1 is the control location, and 2 to 7 are plain storage. Reading location 1 returns the in-service latches in bits 5:0, with bits 7:6 zero. An address with any of bits 7:3 set is unmapped: its writes are dropped and its reads leave the bus undriven.
- R5: During an acknowledge cycle, the address, both selects and `dir_rd` have no effect: no register is written.
- R6: An acknowledge is claimed only if a source is pending and `chain_in` is high at the data-strobe fall. An unclaimed acknowledge leaves the bus undriven and the in-service latches unchanged.
- R7: A claimed acknowledge sets the in-service latch of the lowest-index pending source. It drives the vector {base[7:4], index[2:0], base[0]}.
- R8: A source is not pending while its own in-service latch, or that of any lower-index source, is set.
- R9: `chain_out` is high only if `chain_in` is high, no in-service latch is set, and no acknowledge cycle is open while a source is pending.
- R10: Writing location 1 with bits 5:3 equal to 3'b111 clears the lowest-index set in-service latch. Any other value written there changes nothing.
- R11: While `rst` is high, `bus_oe` and `chain_out` are low, all in-service latches are cleared and all locations read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe_n | input | 1 | Address strobe, captures on rising edge |
| data_strobe_n | input | 1 | Data strobe, active low |
| dir_rd | input | 1 | High for read, low for write |
| sel_early_n | input | 1 | Active-low select taken at address strobe |
| sel_late | input | 1 | Active-high select qualifying the data phase |
| ack_in_n | input | 1 | Active-low interrupt-acknowledge flag |
| chain_in | input | 1 | Daisy-chain enable from higher devices |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data from host |
| irq_src | input | 6 | Raw interrupt requests, index 0 highest |
| bus_rdata | output | 8 | Read data or vector |
| bus_oe | output | 1 | Bus drive enable (low = tri-stated) |
| chain_out | output | 1 | Daisy-chain enable to lower devices |

## Verification
The assertions assume the host follows the strobe protocol. Address, selects and the acknowledge flag are settled before the address strobe rises. `dir_rd`, `bus_wdata`, `irq_src` and `chain_in` stay still for the whole data-strobe phase, and the two strobes never change in the same synchronizer window. The bench holds every input for five clocks before and after each strobe edge, which is longer than the three-flop synchronizer delay. It changes request patterns and chain state only between bus cycles.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;
  localparam int unsigned VBASE_LOC = 0;
  localparam int unsigned CTRL_LOC  = 1;
  localparam int unsigned CMD_LSB   = 3;
  localparam logic [2:0]  CMD_CLEAR_TOP = 3'b111;
endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] m1, m2, m3;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1 <= IDLE;
      m2 <= IDLE;
      m3 <= IDLE;
    end else begin
      m1 <= d;
      m2 <= m1;
      m3 <= m2;
    end
  end

  assign lvl  = m2;
  assign rise = m2 & ~m3;
  assign fall = ~m2 & m3;
endmodule

// File: rtl/strobe_irq_prio.sv
module strobe_irq_prio #(
  parameter int SRC_N = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src,
  input  logic             set_en,
  input  logic             clr_top,
  input  logic             chain_in,
  input  logic             ack_open,
  output logic             any_pend,
  output logic [IDX_W-1:0] top_idx,
  output logic [SRC_N-1:0] ius,
  output logic             chain_out
);
  logic [SRC_N-1:0] blocked, pend, low_ius;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      acc = acc | ius[i];
      blocked[i] = acc;
    end
  end

  assign pend     = src & ~blocked;
  assign any_pend = |pend;
  assign low_ius  = ius & (~ius + SRC_N'(1));

  always_comb begin
    top_idx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pend[i]) top_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ius       <= '0;
      chain_out <= 1'b0;
    end else begin
      if (set_en && any_pend) ius <= ius | (SRC_N'(1) << top_idx);
      else if (clr_top)       ius <= ius & ~low_ius;
      chain_out <= chain_in && !(|ius) && !(ack_open && any_pend);
    end
  end

  p_single_set_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(ius & ~$past(ius)) <= 1);

  p_pend_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    ius[0] |-> !any_pend);

  p_chain_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (|ius) |=> !chain_out);

  p_clear_one_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_top && !set_en && (|ius)) |=> ($countones(ius) == $countones($past(ius)) - 1));
endmodule

// File: rtl/strobe_reg_bank.sv
module strobe_reg_bank
  import strobe_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REGS   = 8,
  parameter int SRC_N  = 6,
  localparam int LOC_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LOC_W-1:0]  rd_idx,
  input  logic [SRC_N-1:0]  ius,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] base,
  output logic              clr_top
);
  logic [DATA_W-1:0] mem [REGS];
  logic ctrl_hit;

  assign ctrl_hit = (wr_idx == LOC_W'(CTRL_LOC));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) mem[i] <= '0;
    end else if (wr_en && !ctrl_hit) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign clr_top = wr_en && ctrl_hit && (wr_data[CMD_LSB +: 3] == CMD_CLEAR_TOP);
  assign base    = mem[VBASE_LOC];

  always_comb begin
    if (rd_idx == LOC_W'(CTRL_LOC)) rd_val = {{(DATA_W-SRC_N){1'b0}}, ius};
    else                            rd_val = mem[rd_idx];
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctrl_hit) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/strobe_host_port.sv
module strobe_host_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SRC_N  = 6,
  parameter int REGS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe_n,
  input  logic              data_strobe_n,
  input  logic              dir_rd,
  input  logic              sel_early_n,
  input  logic              sel_late,
  input  logic              ack_in_n,
  input  logic              chain_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [SRC_N-1:0]  irq_src,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_oe,
  output logic              chain_out
);
  localparam int LOC_W = $clog2(REGS);
  localparam int IDX_W = $clog2(SRC_N);
  localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'(((1 << IDX_W) - 1) << 1);

  logic [2:0] s_lvl, s_rise, s_fall;
  logic as_rise, ds_fall, ds_rise, ds_low, dir_s, sync_unused;

  strobe_edge_sync #(.W(3), .IDLE(3'b111)) u_sync (
    .clk(clk), .rst(rst),
    .d({dir_rd, data_strobe_n, addr_strobe_n}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign as_rise = s_rise[0];
  assign ds_fall = s_fall[1];
  assign ds_rise = s_rise[1];
  assign ds_low  = ~s_lvl[1];
  assign dir_s   = s_lvl[2];
  assign sync_unused = ^{s_lvl[0], s_fall[0], s_rise[2], s_fall[2]};

  logic [ADDR_W-1:0] lat_addr;
  logic lat_sel_n, lat_ack_n, cyc_open, cyc_wr;
  logic ack_mode, reg_sel, claim, wr_en, ack_open;
  logic any_pend, clr_top;
  logic [IDX_W-1:0]  top_idx;
  logic [SRC_N-1:0]  ius;
  logic [DATA_W-1:0] rd_val, base, vector;

  assign ack_mode = !lat_ack_n;
  assign reg_sel  = !lat_sel_n && (lat_addr[ADDR_W-1:LOC_W] == '0);
  assign ack_open = cyc_open && ack_mode;
  assign claim    = ds_fall && ack_open && chain_in && any_pend;
  assign wr_en    = ds_rise && cyc_open && !ack_mode && cyc_wr && reg_sel && sel_late;
  assign vector   = (base & ~IDX_MASK) | (DATA_W'(top_idx) << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr  <= '0;
      lat_sel_n <= 1'b1;
      lat_ack_n <= 1'b1;
      cyc_open  <= 1'b0;
      cyc_wr    <= 1'b0;
      bus_oe    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (as_rise) begin
        lat_addr  <= bus_addr;
        lat_sel_n <= sel_early_n;
        lat_ack_n <= ack_in_n;
        cyc_open  <= 1'b1;
        cyc_wr    <= 1'b0;
      end
      if (bus_oe && (!ds_low || (!ack_mode && !sel_late))) bus_oe <= 1'b0;
      if (ds_fall && cyc_open) begin
        if (ack_mode) begin
          if (claim) begin
            bus_rdata <= vector;
            bus_oe    <= 1'b1;
          end
        end else begin
          cyc_wr <= !dir_s;
          if (dir_s && reg_sel && sel_late) begin
            bus_rdata <= rd_val;
            bus_oe    <= 1'b1;
          end
        end
      end
      if (ds_rise) begin
        cyc_open <= 1'b0;
        cyc_wr   <= 1'b0;
      end
    end
  end

  strobe_reg_bank #(.DATA_W(DATA_W), .REGS(REGS), .SRC_N(SRC_N)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_idx(lat_addr[LOC_W-1:0]), .wr_data(bus_wdata),
    .rd_idx(lat_addr[LOC_W-1:0]), .ius(ius),
    .rd_val(rd_val), .base(base), .clr_top(clr_top)
  );

  strobe_irq_prio #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst), .src(irq_src), .set_en(claim), .clr_top(clr_top),
    .chain_in(chain_in), .ack_open(ack_open), .any_pend(any_pend),
    .top_idx(top_idx), .ius(ius), .chain_out(chain_out)
  );

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !as_rise |=> ($stable(lat_addr) && $stable(lat_ack_n) && $stable(lat_sel_n)));

  p_oe_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(ds_fall));

  p_oe_end_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && ds_rise) |=> !bus_oe);

  p_claim_chain_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_oe) && ack_mode) |-> $past(chain_in));
endmodule

// File: tb/strobe_host_port_bench.sv
module strobe_host_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, addr_strobe_n, data_strobe_n, dir_rd, sel_early_n, sel_late, ack_in_n, chain_in;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [5:0] irq_src;
  logic bus_oe, chain_out;

  strobe_host_port u_strobe_host_port (
    .clk(clk), .rst(rst), .addr_strobe_n(addr_strobe_n), .data_strobe_n(data_strobe_n),
    .dir_rd(dir_rd), .sel_early_n(sel_early_n), .sel_late(sel_late), .ack_in_n(ack_in_n),
    .chain_in(chain_in), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_src(irq_src),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .chain_out(chain_out)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a, input logic sel_n, input logic ack_n);
    bus_addr = a; sel_early_n = sel_n; ack_in_n = ack_n;
    addr_strobe_n = 1'b0; wait_n(5);
    addr_strobe_n = 1'b1; wait_n(5);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                           input logic sel_n, input logic late);
    addr_phase(a, sel_n, 1'b1);
    dir_rd = 1'b0; bus_wdata = d; sel_late = late; wait_n(5);
    data_strobe_n = 1'b0; wait_n(5);
    data_strobe_n = 1'b1; wait_n(5);
    sel_late = 1'b0; dir_rd = 1'b1; sel_early_n = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic late, input logic [7:0] alt_a,
                          output logic [7:0] d, output logic oe, output logic oe_after);
    addr_phase(a, 1'b0, 1'b1);
    bus_addr = alt_a; sel_early_n = 1'b1;
    dir_rd = 1'b1; sel_late = late; wait_n(5);
    data_strobe_n = 1'b0; wait_n(5);
    d = bus_rdata; oe = bus_oe;
    data_strobe_n = 1'b1; wait_n(5);
    oe_after = bus_oe;
    sel_late = 1'b0;
  endtask

  task automatic ack_cycle(output logic [7:0] d, output logic oe, output logic oe_after);
    addr_phase(8'h02, 1'b0, 1'b0);
    ack_in_n = 1'b1;
    dir_rd = 1'b0; sel_late = 1'b1; bus_wdata = 8'h5A; wait_n(5);
    data_strobe_n = 1'b0; wait_n(5);
    d = bus_rdata; oe = bus_oe;
    data_strobe_n = 1'b1; wait_n(5);
    oe_after = bus_oe;
    sel_late = 1'b0; dir_rd = 1'b1; sel_early_n = 1'b1;
  endtask

  function automatic logic [7:0] stored(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic int low_idx(input logic [5:0] v);
    for (int i = 5; i >= 0; i--) if (v[i]) low_idx = i;
    if (v == 6'd0) low_idx = -1;
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic oe, oe2;
    rst = 1'b1; addr_strobe_n = 1'b1; data_strobe_n = 1'b1; dir_rd = 1'b1;
    sel_early_n = 1'b1; sel_late = 1'b0; ack_in_n = 1'b1; chain_in = 1'b1;
    bus_addr = '0; bus_wdata = '0; irq_src = '0;
    wait_n(4);
    check("R11 oe in reset", bus_oe, 0);
    check("R11 chain_out in reset", chain_out, 0);
    rst = 1'b0;
    wait_n(4);
    check("R9 chain idle passes", chain_out, 1);
    bus_read(8'h03, 1'b1, 8'h03, d, oe, oe2);
    check("R11 location reads zero after reset", d, 0);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R11 in-service clear after reset", d, 0);

    // R3 / R4: storage sweep over all mapped locations except control
    for (int i = 0; i < 8; i++) if (i != 1) bus_write(8'(i), stored(i), 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      if (i == 1) continue;
      bus_read(8'(i), 1'b1, 8'(i), d, oe, oe2);
      check("R3 stored value", d, stored(i));
      check("R2 oe during read", oe, 1);
      check("R2 oe released after strobe", oe2, 0);
    end
    // R3: unqualified writes dropped
    bus_write(8'h04, 8'hEE, 1'b1, 1'b1);
    bus_write(8'h05, 8'hEE, 1'b0, 1'b0);
    bus_read(8'h04, 1'b1, 8'h04, d, oe, oe2);
    check("R3 early select high blocks write", d, stored(4));
    bus_read(8'h05, 1'b1, 8'h05, d, oe, oe2);
    check("R3 late select low blocks write", d, stored(5));
    // R2: late select low leaves bus undriven
    bus_read(8'h05, 1'b0, 8'h05, d, oe, oe2);
    check("R2 no drive without late select", oe, 0);
    // R4: unmapped addresses
    for (int k = 1; k < 32; k += 5) begin
      bus_write(8'((k << 3) | 2), 8'hFF, 1'b0, 1'b1);
      bus_read(8'((k << 3) | 2), 1'b1, 8'((k << 3) | 2), d, oe, oe2);
      check("R4 unmapped read undriven", oe, 0);
    end
    bus_read(8'h02, 1'b1, 8'h02, d, oe, oe2);
    check("R4 unmapped write dropped", d, stored(2));
    // R1: address change after capture edge
    bus_read(8'h03, 1'b1, 8'h06, d, oe, oe2);
    check("R1 captured address used", d, stored(3));
    check("R1 captured select used", oe, 1);

    bus_write(8'h00, 8'hA5, 1'b0, 1'b1);
    // R6/R7 sweep over all request patterns
    for (int s = 0; s < 64; s++) begin
      irq_src = 6'(s);
      ack_cycle(d, oe, oe2);
      check("R6 claim iff pending", oe, (s != 0));
      check("R2 vector released", oe2, 0);
      if (s != 0) check("R7 vector", d, {4'hA, 3'(low_idx(6'(s))), 1'b1});
      irq_src = '0;
      bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
      check("R7 in-service bit", d, (s != 0) ? (32'd1 << low_idx(6'(s))) : 0);
      bus_write(8'h01, 8'h38, 1'b0, 1'b1);
      bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
      check("R10 clear to empty", d, 0);
    end
    bus_read(8'h02, 1'b1, 8'h02, d, oe, oe2);
    check("R5 acknowledge did not write", d, stored(2));

    // R8 nesting and R10 ordering
    irq_src = 6'b111110;
    ack_cycle(d, oe, oe2);
    check("R7 nested first vector", d, 8'hA3);
    ack_cycle(d, oe, oe2);
    check("R8 blocked by own latch", oe, 0);
    irq_src = 6'b111111;
    wait_n(3);
    check("R9 chain blocked by in-service", chain_out, 0);
    ack_cycle(d, oe, oe2);
    check("R8 higher source preempts", d, 8'hA1);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R7 two latches", d, 8'h03);
    bus_write(8'h01, 8'h00, 1'b0, 1'b1);
    bus_write(8'h01, 8'h30, 1'b0, 1'b1);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R10 other values ignored", d, 8'h03);
    bus_write(8'h01, 8'h38, 1'b0, 1'b1);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R10 clears highest only", d, 8'h02);
    bus_write(8'h01, 8'h38, 1'b0, 1'b1);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R10 second clear", d, 8'h00);

    // R6: chain input low
    chain_in = 1'b0;
    wait_n(4);
    check("R9 chain follows input low", chain_out, 0);
    ack_cycle(d, oe, oe2);
    check("R6 no claim with chain low", oe, 0);
    bus_read(8'h01, 1'b1, 8'h01, d, oe, oe2);
    check("R6 no latch with chain low", d, 0);
    chain_in = 1'b1;

    // R9: open acknowledge with and without pending source
    irq_src = 6'b000100;
    wait_n(4);
    check("R9 pending alone does not block", chain_out, 1);
    addr_phase(8'h00, 1'b1, 1'b0);
    ack_in_n = 1'b1;
    check("R9 open ack with pending blocks", chain_out, 0);
    data_strobe_n = 1'b0; wait_n(5);
    check("R7 vector source 2", bus_rdata, 8'hA5);
    data_strobe_n = 1'b1; wait_n(5);
    bus_write(8'h01, 8'h38, 1'b0, 1'b1);
    irq_src = '0;
    addr_phase(8'h00, 1'b1, 1'b0);
    ack_in_n = 1'b1;
    check("R9 open ack without pending passes", chain_out, 1);
    data_strobe_n = 1'b0; wait_n(5);
    check("R6 nothing pending no drive", bus_oe, 0);
    data_strobe_n = 1'b1; wait_n(5);

    finish_run();
  end
endmodule